// File: doc/BRIEF.md
# Multicycle FP Issue Interlock

This block sits at the decode stage of an in-order pipeline whose execute side has four units of unequal depth: a single-cycle integer path, a pipelined FP adder, a pipelined FP multiplier and a divider that takes one operation at a time. Each cycle it looks at the instruction held in decode and raises a stall when issuing it now would be unsafe. It stalls for four reasons: the divider is still occupied, a source operand is still being computed, an older in-flight write to the same destination would land at the same time as this one or after it, or the shared write-back port is already booked for the cycle this instruction would need. Operands are read in decode, so write-after-read ordering never needs a check.

The block keeps two kinds of state. A per-register countdown records how many cycles remain until each pending result can be forwarded. A shift vector of booked write-back slots moves one place toward the present every cycle. An instruction issues in any cycle where `id_valid` is high and `stall` is low. A stalled instruction changes no state, and decode simply offers it again in the next cycle. Integer and FP registers are separate files that share one index space, and dependences are matched only within one file. Both files use the same write-back port.

Top module: `fp_issue_interlock`

## Requirements
- R1: After reset no register is pending, the divider is free and no write-back slot is booked, so the first valid instruction is not stalled.
- R2: `stall` is low in every cycle where `id_valid` is low.
- R3: The divider accepts one operation at a time. A divide (unit code 3) offered k cycles after an earlier divide issued stalls while k < 24 and may issue at k = 24.
- R4: With forwarding, an instruction that reads a register written by a producer of latency L (integer 0, add 3, multiply 6, divide 24; unit codes 0, 1, 2, 3) stalls while fewer than L+1 cycles have passed since the producer issued. An integer producer therefore never stalls its consumer.
- R5: An instruction whose write to a register would reach write-back no later than a write already in flight to the same register stalls. A later writer with a longer latency does not stall.
- R6: An instruction with latency L that issues in cycle t writes back in cycle t+L+2. Two writes never share a write-back cycle, and the younger instruction stalls until its slot is free, whichever register file either instruction writes.
- R7: The same index in the integer and the FP file names two different registers and never causes a RAW or WAW stall.
- R8: A source whose enable is low causes no RAW stall, and a destination whose enable is low books no slot, causes no WAW stall and marks no register pending, whatever index is driven.
- R9: A stalled instruction has no effect. It marks no register pending, books no write-back slot and does not start the divider.
- R10: The adder and the multiplier are pipelined. Independent adds and multiplies may issue in back-to-back cycles without stalling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_valid | input | 1 | An instruction is present in decode |
| id_unit | input | 2 | Execution unit: 0 integer, 1 FP add, 2 FP multiply, 3 FP divide |
| id_src_a_en | input | 1 | First source operand is used |
| id_src_a_fp | input | 1 | First source is in the FP file (0 selects the integer file) |
| id_src_a | input | $clog2(NREG) | First source register index |
| id_src_b_en | input | 1 | Second source operand is used |
| id_src_b_fp | input | 1 | Second source is in the FP file |
| id_src_b | input | $clog2(NREG) | Second source register index |
| id_dst_en | input | 1 | Instruction writes a destination register |
| id_dst_fp | input | 1 | Destination is in the FP file |
| id_dst | input | $clog2(NREG) | Destination register index |
| stall | output | 1 | Hold the decode instruction this cycle |

## Verification
Dependent chains behind an add, a multiply and an integer producer measure the exact length of the RAW window for each latency, so an off-by-one in the countdown shows up as a stall that starts or ends one cycle early. Back-to-back divides probe the last busy cycle of the divider. A multiply followed by an add to the same register, and then to a different one, separates a WAW stall from a write-port collision. A multiply followed a few cycles later by an add or an integer write aimed at the same write-back cycle checks that slot bookings line up across units and across register files. Further patterns reuse one index in both files, drive indices with their enables low, offer a stalled divide whose destination is read right after, and stream independent adds and multiplies. Together these show that the register files are kept apart, that disabled fields are ignored, that a stalled instruction leaves no trace and that the pipelined units never stall one another.

// File: rtl/fpil_pkg.sv
// Package for the FP issue interlock.
// Holds the execution-unit encoding that decode drives on id_unit and a
// helper that picks the largest of the unit latencies.
package fpil_pkg;

    typedef enum logic [1:0] {
        UNIT_INT = 2'd0,
        UNIT_ADD = 2'd1,
        UNIT_MUL = 2'd2,
        UNIT_DIV = 2'd3
    } unit_e;

    // Largest of four latencies, used to size counters and the slot vector.
    function automatic int lat_max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/fpil_wb_slots.sv
// Write-back slot book.
// Bit i of the vector means a write-back is already booked i+1 cycles from
// now. The vector moves one place toward bit 0 each cycle. An instruction of
// latency L issued now writes back L+2 cycles later, so it probes bit L+1
// and, once it issues, books bit L of the next-cycle vector.
// Assumes lat never exceeds SLOTS-2.
module fpil_wb_slots #(
    parameter int SLOTS = 26,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          want,
    input  logic          claim,
    input  logic [CW-1:0] lat,
    output logic          clash
);

    logic [SLOTS-1:0] slot_q;
    logic [SLOTS-1:0] book_vec;
    logic             probe;

    // Decode the slot the issuing instruction books in the next cycle.
    always_comb begin
        book_vec = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (claim && (lat == CW'(i))) book_vec[i] = 1'b1;
        end
    end

    // Read the slot the candidate instruction would use.
    always_comb begin
        probe = 1'b0;
        for (int i = 1; i < SLOTS; i++) begin
            if (lat == CW'(i - 1)) probe = slot_q[i];
        end
    end

    assign clash = want && probe;

    // Advance the booking vector and add the new booking.
    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= (slot_q >> 1) | book_vec;
    end

endmodule

// File: rtl/fpil_pend_file.sv
// Pending-result table for one register file.
// Each register has a countdown of the cycles left until its newest producer
// can forward. The countdown loads the producer latency on issue and counts
// down to zero. A source that reads a register with a non-zero count is a
// RAW hit. A new writer whose latency is smaller than the remaining count
// would write back no later than the older writer, which is a WAW hit.
module fpil_pend_file #(
    parameter int NREG = 32,
    parameter int RW   = 5,
    parameter int CW   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_a_en,
    input  logic [RW-1:0] rd_a,
    input  logic          rd_b_en,
    input  logic [RW-1:0] rd_b,
    input  logic          wr_chk,
    input  logic          wr_load,
    input  logic [RW-1:0] wr_idx,
    input  logic [CW-1:0] wr_lat,
    output logic          raw_hit,
    output logic          waw_hit
);

    logic [CW-1:0] left_q [NREG];

    // Flag sources whose producer has not reached forwarding yet.
    assign raw_hit = (rd_a_en && (left_q[rd_a] != '0)) ||
                     (rd_b_en && (left_q[rd_b] != '0));

    // Flag a writer that would finish no later than the older one in flight.
    assign waw_hit = wr_chk && (left_q[wr_idx] > wr_lat);

    // Load a countdown on issue, otherwise count each pending entry down.
    always_ff @(posedge clk) begin
        for (int r = 0; r < NREG; r++) begin
            if (!rst_n)
                left_q[r] <= '0;
            else if (wr_load && (wr_idx == RW'(r)))
                left_q[r] <= wr_lat;
            else if (left_q[r] != '0)
                left_q[r] <= left_q[r] - 1'b1;
        end
    end

endmodule

// File: rtl/fpil_div_gate.sv
// Occupancy tracker for the unpipelined divider.
// A divide that starts in cycle t holds the unit until t+DIV_LAT-1, so the
// next divide may start in cycle t+DIV_LAT. Assumes DIV_LAT >= 1.
module fpil_div_gate #(
    parameter int CW      = 5,
    parameter int DIV_LAT = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    logic [CW-1:0] hold_q;

    assign busy = (hold_q != '0);

    // Load the remaining occupancy on a start and count it down.
    always_ff @(posedge clk) begin
        if (!rst_n)              hold_q <= '0;
        else if (start)          hold_q <= CW'(DIV_LAT - 1);
        else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
    end

endmodule

// File: rtl/fp_issue_interlock.sv
// Decode-stage issue interlock for a pipeline with units of unequal latency.
// Combines four stall sources for the instruction in decode: divider busy,
// RAW on a pending result, WAW against an in-flight write that would finish
// no earlier, and a booked write-back slot. The instruction issues when
// id_valid is high and stall is low. Nothing changes state when it stalls.
// Assumes LAT_DIV is the largest latency that matters for sizing, and that
// integer and FP registers are separate files of NREG entries each.
module fp_issue_interlock
    import fpil_pkg::*;
#(
    parameter int NREG    = 32,
    parameter int LAT_INT = 0,
    parameter int LAT_ADD = 3,
    parameter int LAT_MUL = 6,
    parameter int LAT_DIV = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    id_valid,
    input  logic [1:0]              id_unit,
    input  logic                    id_src_a_en,
    input  logic                    id_src_a_fp,
    input  logic [$clog2(NREG)-1:0] id_src_a,
    input  logic                    id_src_b_en,
    input  logic                    id_src_b_fp,
    input  logic [$clog2(NREG)-1:0] id_src_b,
    input  logic                    id_dst_en,
    input  logic                    id_dst_fp,
    input  logic [$clog2(NREG)-1:0] id_dst,
    output logic                    stall
);

    localparam int RW      = $clog2(NREG);
    localparam int LAT_MAX = lat_max4(LAT_INT, LAT_ADD, LAT_MUL, LAT_DIV);
    localparam int SLOTS   = LAT_MAX + 2;
    localparam int CW      = $clog2(LAT_MAX + 1);

    unit_e         unit_w;
    logic [CW-1:0] lat_w;
    logic          is_div;
    logic          issue;
    logic          hazard;
    logic          div_busy;
    logic          port_clash;
    logic [1:0]    raw_f;
    logic [1:0]    waw_f;

    assign unit_w = unit_e'(id_unit);
    assign is_div = (unit_w == UNIT_DIV);

    // Map the unit code to its execution latency.
    always_comb begin
        case (unit_w)
            UNIT_ADD: lat_w = CW'(LAT_ADD);
            UNIT_MUL: lat_w = CW'(LAT_MUL);
            UNIT_DIV: lat_w = CW'(LAT_DIV);
            default:  lat_w = CW'(LAT_INT);
        endcase
    end

    // One pending table per register file, selected by the operand file bits.
    for (genvar f = 0; f < 2; f++) begin : g_file
        logic sel_a;
        logic sel_b;
        logic sel_d;

        assign sel_a = id_src_a_en && (id_src_a_fp == 1'(f));
        assign sel_b = id_src_b_en && (id_src_b_fp == 1'(f));
        assign sel_d = id_dst_en   && (id_dst_fp   == 1'(f));

        fpil_pend_file #(
            .NREG (NREG),
            .RW   (RW),
            .CW   (CW)
        ) i_pend (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_a_en (sel_a),
            .rd_a    (id_src_a),
            .rd_b_en (sel_b),
            .rd_b    (id_src_b),
            .wr_chk  (sel_d),
            .wr_load (issue && sel_d),
            .wr_idx  (id_dst),
            .wr_lat  (lat_w),
            .raw_hit (raw_f[f]),
            .waw_hit (waw_f[f])
        );
    end

    // Shared write-back port booking.
    fpil_wb_slots #(
        .SLOTS (SLOTS),
        .CW    (CW)
    ) i_slots (
        .clk   (clk),
        .rst_n (rst_n),
        .want  (id_dst_en),
        .claim (issue && id_dst_en),
        .lat   (lat_w),
        .clash (port_clash)
    );

    // Divider occupancy.
    fpil_div_gate #(
        .CW      (CW),
        .DIV_LAT (LAT_DIV)
    ) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (issue && is_div),
        .busy  (div_busy)
    );

    // Combine the stall sources and derive issue.
    assign hazard = (|raw_f) || (|waw_f) || port_clash || (is_div && div_busy);
    assign stall  = id_valid && hazard;
    assign issue  = id_valid && !hazard;

endmodule

// File: rtl/fpil_chk.sv
// Property checker for fp_issue_interlock, attached with bind.
// Observes only the ports of the interlock. Issue is recomputed as
// id_valid && !stall. The latency-dependent properties assume the default
// latencies (multiply longer than add by more than one cycle, divide > 1).
module fpil_chk #(
    parameter int IW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          id_valid,
    input logic [1:0]    id_unit,
    input logic          id_src_a_en,
    input logic          id_src_a_fp,
    input logic [IW-1:0] id_src_a,
    input logic          id_src_b_en,
    input logic          id_dst_en,
    input logic          id_dst_fp,
    input logic [IW-1:0] id_dst,
    input logic          stall
);

    logic took;
    assign took = id_valid && !stall;

    // R2
    idle_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |-> !stall);

    // R3
    div_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (took && id_unit == 2'd3) |=> (!(id_valid && id_unit == 2'd3) || stall));

    // R4
    raw_after_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (took && id_unit == 2'd1 && id_dst_en) |=>
        (!(id_valid && id_src_a_en && id_src_a_fp == $past(id_dst_fp) &&
           id_src_a == $past(id_dst)) || stall));

    // R5
    waw_add_after_mul_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (took && id_unit == 2'd2 && id_dst_en) |=>
        (!(id_valid && id_unit == 2'd1 && id_dst_en &&
           id_dst_fp == $past(id_dst_fp) && id_dst == $past(id_dst)) || stall));

    // R8
    no_operand_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && !id_dst_en && !id_src_a_en && !id_src_b_en && id_unit != 2'd3)
        |-> !stall);

endmodule

bind fp_issue_interlock fpil_chk #(.IW(RW)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .id_valid    (id_valid),
    .id_unit     (id_unit),
    .id_src_a_en (id_src_a_en),
    .id_src_a_fp (id_src_a_fp),
    .id_src_a    (id_src_a),
    .id_src_b_en (id_src_b_en),
    .id_dst_en   (id_dst_en),
    .id_dst_fp   (id_dst_fp),
    .id_dst      (id_dst),
    .stall       (stall)
);

// File: tb/test_fp_issue_interlock.sv
`timescale 1ns/1ps
// Directed bench for fp_issue_interlock. Inputs change on the falling edge,
// stall is sampled 1 ns later, and the instruction issues on the next rising
// edge. Each op call is one cycle.
module test_fp_issue_interlock;

    localparam logic [1:0] U_INT = 2'd0;
    localparam logic [1:0] U_ADD = 2'd1;
    localparam logic [1:0] U_MUL = 2'd2;
    localparam logic [1:0] U_DIV = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       id_valid = 1'b0;
    logic [1:0] id_unit = 2'd0;
    logic       id_src_a_en = 1'b0;
    logic       id_src_a_fp = 1'b0;
    logic [4:0] id_src_a = '0;
    logic       id_src_b_en = 1'b0;
    logic       id_src_b_fp = 1'b0;
    logic [4:0] id_src_b = '0;
    logic       id_dst_en = 1'b0;
    logic       id_dst_fp = 1'b0;
    logic [4:0] id_dst = '0;
    logic       stall;

    int tests  = 0;
    int failed = 0;
    int dis_idx = 0;

    always #2.5 clk = ~clk;

    fp_issue_interlock i_fp_issue_interlock (
        .clk         (clk),
        .rst_n       (rst_n),
        .id_valid    (id_valid),
        .id_unit     (id_unit),
        .id_src_a_en (id_src_a_en),
        .id_src_a_fp (id_src_a_fp),
        .id_src_a    (id_src_a),
        .id_src_b_en (id_src_b_en),
        .id_src_b_fp (id_src_b_fp),
        .id_src_b    (id_src_b),
        .id_dst_en   (id_dst_en),
        .id_dst_fp   (id_dst_fp),
        .id_dst      (id_dst),
        .stall       (stall)
    );

    task automatic check(input logic got, input logic exp, input string req, input string what);
        tests++;
        if (got !== exp) begin
            failed++;
            $display("FAIL %s %s: stall=%0b expected %0b", req, what, got, exp);
        end
    endtask

    // One decode cycle. Negative indices mean the field is disabled; a
    // disabled field still drives dis_idx on its index lines.
    task automatic op(input logic [1:0] u, input logic dfp, input int d,
                      input logic sfp, input int sa, input int sb,
                      input logic exp, input string req, input string what);
        @(negedge clk);
        id_valid    = 1'b1;
        id_unit     = u;
        id_dst_en   = (d >= 0);
        id_dst_fp   = dfp;
        id_dst      = (d >= 0) ? 5'(d) : 5'(dis_idx);
        id_src_a_en = (sa >= 0);
        id_src_a_fp = sfp;
        id_src_a    = (sa >= 0) ? 5'(sa) : 5'(dis_idx);
        id_src_b_en = (sb >= 0);
        id_src_b_fp = sfp;
        id_src_b    = (sb >= 0) ? 5'(sb) : 5'(dis_idx);
        #1;
        check(stall, exp, req, what);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            id_valid = 1'b0;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        id_valid = 1'b1; id_unit = U_DIV; id_dst_en = 1'b1; id_dst_fp = 1'b1; id_dst = 5'd3;
        #1 check(stall, 1'b0, "R1", "divide offered while in reset");
        @(negedge clk);
        id_valid = 1'b0;
        rst_n = 1'b1;
        op(U_DIV, 1, 3, 1, 3, 3, 0, "R1", "first instruction after reset");
        @(negedge clk);
        id_valid = 1'b0; id_unit = U_DIV; id_src_a_en = 1'b1; id_src_a = 5'd3;
        #1 check(stall, 1'b0, "R2", "invalid divide while divider busy");
        idle(30);
    endtask

    task automatic t_raw();
        op(U_ADD, 1, 1, 1, -1, -1, 0, "R4", "add producer f1");
        for (int k = 1; k <= 4; k++)
            op(U_ADD, 1, 2, 1, -1, 1, (k < 4), "R4", $sformatf("reader of f1 at +%0d", k));
        idle(10);
        op(U_MUL, 1, 3, 1, -1, -1, 0, "R4", "mul producer f3");
        for (int k = 1; k <= 7; k++)
            op(U_INT, 0, -1, 1, 3, -1, (k < 7), "R4", $sformatf("reader of f3 at +%0d", k));
        op(U_INT, 0, 5, 0, -1, -1, 0, "R4", "int producer r5");
        op(U_INT, 0, 6, 0, 5, -1, 0, "R4", "int reader of r5 next cycle");
        idle(30);
    endtask

    task automatic t_div();
        op(U_DIV, 1, 4, 1, -1, -1, 0, "R3", "first divide");
        for (int k = 1; k <= 24; k++)
            op(U_DIV, 1, 6, 1, -1, -1, (k < 24), "R3", $sformatf("second divide at +%0d", k));
        idle(30);
    endtask

    task automatic t_waw();
        op(U_MUL, 1, 5, 1, -1, -1, 0, "R5", "mul to f5");
        for (int k = 1; k <= 4; k++)
            op(U_ADD, 1, 5, 1, -1, -1, (k < 4), "R5", $sformatf("add to f5 at +%0d", k));
        idle(30);
        op(U_MUL, 1, 5, 1, -1, -1, 0, "R5", "mul to f5 again");
        op(U_ADD, 1, 7, 1, -1, -1, 0, "R5", "add to other reg f7 at +1");
        idle(30);
        op(U_ADD, 1, 5, 1, -1, -1, 0, "R5", "add to f5");
        op(U_MUL, 1, 5, 1, -1, -1, 0, "R5", "longer mul to f5 at +1");
        idle(30);
    endtask

    task automatic t_port();
        op(U_MUL, 1, 8, 1, -1, -1, 0, "R6", "mul f8 books t+8");
        idle(2);
        op(U_ADD, 1, 9, 1, -1, -1, 1, "R6", "add at +3 wants t+8");
        op(U_ADD, 1, 9, 1, -1, -1, 0, "R6", "add at +4 wants t+9");
        idle(30);
        op(U_MUL, 1, 8, 1, -1, -1, 0, "R6", "mul f8 books t+8");
        idle(5);
        op(U_INT, 0, 1, 0, -1, -1, 1, "R6", "int write r1 at +6 wants t+8");
        op(U_INT, 0, 1, 0, -1, -1, 0, "R6", "int write r1 at +7");
        idle(30);
        op(U_MUL, 1, 8, 1, -1, -1, 0, "R8", "mul f8 books t+8");
        idle(5);
        op(U_INT, 0, -1, 0, -1, -1, 0, "R8", "int with no dest at +6");
        idle(30);
    endtask

    task automatic t_files();
        op(U_ADD, 1, 10, 1, -1, -1, 0, "R7", "add to f10");
        op(U_INT, 0, 11, 0, 10, 10, 0, "R7", "int reads r10");
        op(U_INT, 0, 10, 0, -1, -1, 0, "R7", "int writes r10");
        op(U_INT, 0, -1, 1, 10, -1, 1, "R7", "int reads f10 still pending");
        idle(30);
    endtask

    task automatic t_disabled();
        dis_idx = 11;
        op(U_MUL, 1, 11, 1, -1, -1, 0, "R8", "mul to f11");
        op(U_ADD, 1, -1, 1, -1, -1, 0, "R8", "add with f11 on disabled fields");
        idle(30);
        op(U_MUL, 1, -1, 1, -1, -1, 0, "R8", "mul without dest, idx 11");
        op(U_ADD, 1, 12, 1, 11, -1, 0, "R8", "read f11 after dest-less mul");
        dis_idx = 0;
        idle(30);
    endtask

    task automatic t_stalled();
        op(U_DIV, 1, 12, 1, -1, -1, 0, "R9", "divide to f12");
        op(U_DIV, 1, 13, 1, -1, -1, 1, "R9", "second divide to f13 stalls");
        op(U_ADD, 1, 14, 1, 13, -1, 0, "R9", "read f13 after stalled divide");
        idle(30);
        op(U_MUL, 1, 20, 1, -1, -1, 0, "R9", "mul f20 books t+8");
        idle(2);
        op(U_ADD, 1, 21, 1, -1, -1, 1, "R9", "add at +3 stalls on slot");
        idle(2);
        op(U_ADD, 1, 22, 1, -1, -1, 0, "R9", "add at +6 wants t+11");
        op(U_INT, 0, 2, 0, -1, -1, 0, "R9", "int at +7 wants t+9, free");
        idle(30);
    endtask

    task automatic t_pipe();
        for (int k = 0; k < 4; k++)
            op(U_ADD, 1, 13 + k, 1, -1, -1, 0, "R10", $sformatf("add %0d back to back", k));
        for (int k = 0; k < 4; k++)
            op(U_MUL, 1, 24 + k, 1, -1, -1, 0, "R10", $sformatf("mul %0d back to back", k));
        idle(30);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        failed++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        t_reset();
        t_raw();
        t_div();
        t_waw();
        t_port();
        t_files();
        t_disabled();
        t_stalled();
        t_pipe();
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

endmodule